// File: doc/BRIEF.md
# Legacy and Message Interrupt Generator

This block converts per-vector interrupt requests from inside a device into descriptors for an outbound request stream. It supports three signalling styles. In the wire-emulation style, the OR of all request lines acts as a level-sensitive interrupt line. Each change of that level is sent as an assert message or a deassert message, tagged with the selected pin (A to D).

In the single-address message style, every vector is sent as a memory write to one programmed address. The programmed data carries the vector number in its low bits. In the table style, each vector has its own address, data and mask bit, held in a small register array that a simple write port loads. As soon as either message style is enabled, wire emulation stops and the virtual line is released.

The output is a single descriptor register with a valid/ready handshake. Packet building and the host side are outside this block.

Top module: `intGen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid` is 0. After reset, all table entries are masked and no vector is pending.
- R2: With both message enables low, each rise of the OR of `srcReq` from 0 to 1 produces exactly one descriptor with `outKind`=1 (assert message) and `outPin`=`legacyPin`.
- R3: With both message enables low, each fall of that OR level produces exactly one descriptor with `outKind`=2 (deassert message). A source that rises while the level is already high produces no message.
- R4: While `msiEn` or `tableEn` is high, no assert message is issued. If the virtual line was last signalled as asserted when a message mode turns on, one deassert message is sent before any vector is served.
- R5: With `msiEn`=1 and `tableEn`=0, the block works in single-address mode. A rising edge of `srcReq[i]` produces one descriptor with `outKind`=0 (memory write), `outAddr`=`msiAddr` and `outPin`=0. `outData` equals `msiData`, except that its low n bits hold the low n bits of i, where n = min(`msiVecLog2`, 5).
- R6: With `tableEn`=1, the block works in table mode regardless of `msiEn`. A rising edge of `srcReq[i]` produces a memory write descriptor carrying table entry i's address and data. An entry is written when `tblWe` is high, at index `tblIdx`.
- R7: In table mode, a request to a vector whose mask bit is set is held pending and produces no descriptor. It is sent once the entry is rewritten with its mask bit clear.
- R8: Pending vectors are served lowest index first, one descriptor per accepted handshake. A pending legacy message goes ahead of any vector.
- R9: While `outValid`=1 and `outReady`=0, the descriptor fields stay unchanged and `outValid` stays high.
- R10: A rising source edge that occurs while both message enables are low does not create a pending vector. Enabling a message mode later sends no memory write for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_VEC | Per-vector request levels |
| msiEn | input | 1 | Single-address message mode enable |
| tableEn | input | 1 | Table message mode enable (wins over msiEn) |
| legacyPin | input | 2 | Emulated pin, 0=A .. 3=D |
| msiAddr | input | ADDR_W | Single-address mode target address |
| msiData | input | DATA_W | Single-address mode base data |
| msiVecLog2 | input | 3 | Log2 of enabled vector count (clamped to 5) |
| tblWe | input | 1 | Table entry write strobe |
| tblIdx | input | IDX_W | Table entry index |
| tblAddr | input | ADDR_W | Table entry address |
| tblData | input | DATA_W | Table entry data |
| tblMask | input | 1 | Table entry mask bit |
| outValid | output | 1 | Descriptor valid |
| outReady | input | 1 | Descriptor accepted when high with outValid |
| outKind | output | 2 | 0 memory write, 1 assert message, 2 deassert message |
| outAddr | output | ADDR_W | Write address (0 for messages) |
| outData | output | DATA_W | Write data (0 for messages) |
| outPin | output | 2 | Emulated pin for messages, 0 for writes |

## Verification
The checker assumes two things about the inputs. First, `outReady` is a plain acceptance signal that can be held low for any length of time. Second, `legacyPin` does not change while a legacy message is waiting at the output. The alternation check additionally assumes that the downstream side eventually accepts every descriptor.

The directed stimulus drives all inputs on the falling clock edge. It changes `legacyPin` and the mode enables only while the output is idle. It stalls `outReady` on purpose to exercise the hold rule, and it accepts every descriptor it expects before moving on.

// File: rtl/intGenPkg.sv
package intGenPkg;

  typedef enum logic [1:0] {
    KIND_MEMWR    = 2'd0,
    KIND_ASSERT   = 2'd1,
    KIND_DEASSERT = 2'd2
  } descKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLeg;    // capture a legacy message
    logic legAssert;  // 1: assert message, 0: deassert message
    logic loadVec;    // capture a vector memory write
  } ctlStrobe_t;

  localparam int MAX_VEC_LOG2 = 5;

endpackage

// File: rtl/intGenCtrl.sv
module intGenCtrl
  import intGenPkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] srcReq,
  input  logic               msiEn,
  input  logic               tableEn,
  input  logic [NUM_VEC-1:0] maskVec,
  input  logic               busy,
  output ctlStrobe_t         strobe,
  output logic [IDX_W-1:0]   vecIdx
);

  logic [NUM_VEC-1:0] prevReq;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] riseVec;
  logic [NUM_VEC-1:0] elig;
  logic [NUM_VEC-1:0] clrVec;
  logic               sentLevel;
  logic               msgMode;
  logic               legTarget;
  logic               legNeed;
  logic               pickAny;
  logic [IDX_W-1:0]   pickIdx;

  assign msgMode   = msiEn | tableEn;
  assign legTarget = (|srcReq) & ~msgMode;
  assign legNeed   = legTarget != sentLevel;
  assign riseVec   = srcReq & ~prevReq;
  assign elig      = tableEn ? (pend & ~maskVec) : pend;

  // fixed priority, lowest index wins
  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pickAny = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (!busy) begin
      if (legNeed) begin
        strobe.loadLeg   = 1'b1;
        strobe.legAssert = legTarget;
      end else if (msgMode && pickAny) begin
        strobe.loadVec = 1'b1;
      end
    end
  end

  assign vecIdx = pickIdx;

  always_comb begin
    clrVec = '0;
    if (strobe.loadVec) clrVec[pickIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq   <= '0;
      pend      <= '0;
      sentLevel <= 1'b0;
    end else begin
      prevReq <= srcReq;
      // a fresh edge wins over the clear of the same vector
      pend    <= (pend & ~clrVec) | (riseVec & {NUM_VEC{msgMode}});
      if (strobe.loadLeg) sentLevel <= strobe.legAssert;
    end
  end

endmodule

// File: rtl/intGenDatapath.sv
module intGenDatapath
  import intGenPkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic               tableEn,
  input  logic [1:0]         legacyPin,
  input  logic [ADDR_W-1:0]  msiAddr,
  input  logic [DATA_W-1:0]  msiData,
  input  logic [2:0]         msiVecLog2,
  input  logic               tblWe,
  input  logic [IDX_W-1:0]   tblIdx,
  input  logic [ADDR_W-1:0]  tblAddr,
  input  logic [DATA_W-1:0]  tblData,
  input  logic               tblMask,
  output logic [NUM_VEC-1:0] maskVec,
  output logic               outValid,
  input  logic               outReady,
  output descKind_e          outKind,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [DATA_W-1:0]  outData,
  output logic [1:0]         outPin
);

  logic [ADDR_W-1:0] entAddr [NUM_VEC];
  logic [DATA_W-1:0] entData [NUM_VEC];
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] msiVecData;
  logic [2:0]        effLog2;

  genvar g;
  generate
    for (g = 0; g < NUM_VEC; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entAddr[g] <= '0;
          entData[g] <= '0;
          maskVec[g] <= 1'b1;
        end else if (tblWe && tblIdx == IDX_W'(g)) begin
          entAddr[g] <= tblAddr;
          entData[g] <= tblData;
          maskVec[g] <= tblMask;
        end
      end
    end
  endgenerate

  assign effLog2    = (msiVecLog2 > 3'(MAX_VEC_LOG2)) ? 3'(MAX_VEC_LOG2) : msiVecLog2;
  assign lowMask    = (DATA_W'(1) << effLog2) - DATA_W'(1);
  assign msiVecData = (msiData & ~lowMask) | (DATA_W'(vecIdx) & lowMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= KIND_MEMWR;
      outAddr  <= '0;
      outData  <= '0;
      outPin   <= '0;
    end else if (strobe.loadLeg) begin
      outValid <= 1'b1;
      outKind  <= strobe.legAssert ? KIND_ASSERT : KIND_DEASSERT;
      outAddr  <= '0;
      outData  <= '0;
      outPin   <= legacyPin;
    end else if (strobe.loadVec) begin
      outValid <= 1'b1;
      outKind  <= KIND_MEMWR;
      outAddr  <= tableEn ? entAddr[vecIdx] : msiAddr;
      outData  <= tableEn ? entData[vecIdx] : msiVecData;
      outPin   <= '0;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/intGen.sv
module intGen
  import intGenPkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] srcReq,
  input  logic               msiEn,
  input  logic               tableEn,
  input  logic [1:0]         legacyPin,
  input  logic [ADDR_W-1:0]  msiAddr,
  input  logic [DATA_W-1:0]  msiData,
  input  logic [2:0]         msiVecLog2,
  input  logic               tblWe,
  input  logic [IDX_W-1:0]   tblIdx,
  input  logic [ADDR_W-1:0]  tblAddr,
  input  logic [DATA_W-1:0]  tblData,
  input  logic               tblMask,
  output logic               outValid,
  input  logic               outReady,
  output logic [1:0]         outKind,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [DATA_W-1:0]  outData,
  output logic [1:0]         outPin
);

  ctlStrobe_t         strobe;
  logic [IDX_W-1:0]   vecIdx;
  logic [NUM_VEC-1:0] maskVec;
  descKind_e          kindQ;

  intGenCtrl #(.NUM_VEC(NUM_VEC)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .srcReq  (srcReq),
    .msiEn   (msiEn),
    .tableEn (tableEn),
    .maskVec (maskVec),
    .busy    (outValid),
    .strobe  (strobe),
    .vecIdx  (vecIdx)
  );

  intGenDatapath #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .vecIdx     (vecIdx),
    .tableEn    (tableEn),
    .legacyPin  (legacyPin),
    .msiAddr    (msiAddr),
    .msiData    (msiData),
    .msiVecLog2 (msiVecLog2),
    .tblWe      (tblWe),
    .tblIdx     (tblIdx),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .tblMask    (tblMask),
    .maskVec    (maskVec),
    .outValid   (outValid),
    .outReady   (outReady),
    .outKind    (kindQ),
    .outAddr    (outAddr),
    .outData    (outData),
    .outPin     (outPin)
  );

  assign outKind = kindQ;

endmodule

// File: rtl/intGenChk.sv
module intGenChk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              msiEn,
  input logic              tableEn,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outKind,
  input logic [ADDR_W-1:0] outAddr,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outPin
);

  logic lastAsserted;
  logic accept;

  assign accept = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) lastAsserted <= 1'b0;
    else if (accept && outKind == 2'd1) lastAsserted <= 1'b1;
    else if (accept && outKind == 2'd2) lastAsserted <= 1'b0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rstN) |-> !outValid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKind) && $stable(outAddr)
                                 && $stable(outData) && $stable(outPin)));

  // R4
  no_assert_in_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outValid) && outKind == 2'd1) |-> $past(!(msiEn || tableEn)));

  // R2
  assert_alternates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && outKind == 2'd1) |-> !lastAsserted);

  // R3
  deassert_alternates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && outKind == 2'd2) |-> lastAsserted);

  // R5
  legal_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outKind != 2'd3));

endmodule

bind intGen intGenChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .msiEn    (msiEn),
  .tableEn  (tableEn),
  .outValid (outValid),
  .outReady (outReady),
  .outKind  (outKind),
  .outAddr  (outAddr),
  .outData  (outData),
  .outPin   (outPin)
);

// File: tb/sim_intGen.sv
`timescale 1ns/1ps
module sim_intGen;

  localparam int NUM_VEC = 8;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_VEC-1:0] srcReq = '0;
  logic               msiEn = 1'b0;
  logic               tableEn = 1'b0;
  logic [1:0]         legacyPin = 2'd0;
  logic [ADDR_W-1:0]  msiAddr = '0;
  logic [DATA_W-1:0]  msiData = '0;
  logic [2:0]         msiVecLog2 = 3'd0;
  logic               tblWe = 1'b0;
  logic [IDX_W-1:0]   tblIdx = '0;
  logic [ADDR_W-1:0]  tblAddr = '0;
  logic [DATA_W-1:0]  tblData = '0;
  logic               tblMask = 1'b0;
  logic               outValid;
  logic               outReady = 1'b0;
  logic [1:0]         outKind;
  logic [ADDR_W-1:0]  outAddr;
  logic [DATA_W-1:0]  outData;
  logic [1:0]         outPin;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  intGen #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .msiEn(msiEn), .tableEn(tableEn),
    .legacyPin(legacyPin), .msiAddr(msiAddr), .msiData(msiData),
    .msiVecLog2(msiVecLog2), .tblWe(tblWe), .tblIdx(tblIdx), .tblAddr(tblAddr),
    .tblData(tblData), .tblMask(tblMask), .outValid(outValid),
    .outReady(outReady), .outKind(outKind), .outAddr(outAddr),
    .outData(outData), .outPin(outPin)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // wait for a descriptor, compare, stall, recheck, accept
  task automatic expectDesc(input logic [1:0] k, input logic [31:0] a,
                            input logic [31:0] d, input logic [1:0] p,
                            input int stall, input string req);
    int n = 0;
    while (!outValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(outValid === 1'b1, req, $sformatf("outValid actual %b expected 1", outValid));
    if (outValid) begin
      check(outKind === k && outAddr === a && outData === d && outPin === p, req,
            $sformatf("kind/addr/data/pin actual %0d/%h/%h/%0d expected %0d/%h/%h/%0d",
                      outKind, outAddr, outData, outPin, k, a, d, p));
      if (stall > 0) begin
        repeat (stall) @(negedge clk);
        // R9 held while not ready
        check(outValid === 1'b1 && outKind === k && outAddr === a && outData === d,
              "R9", $sformatf("held kind/addr/data actual %b %0d/%h/%h expected 1 %0d/%h/%h",
                              outValid, outKind, outAddr, outData, k, a, d));
      end
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
    end
  endtask

  task automatic expectNone(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (outValid) seen = 1'b1;
    end
    check(!seen, req, $sformatf("unexpected descriptor kind %0d actual valid 1 expected 0", outKind));
  endtask

  task automatic writeEntry(input int idx, input logic [31:0] a, input logic [31:0] d,
                            input logic m);
    tblIdx  = IDX_W'(idx);
    tblAddr = a;
    tblData = d;
    tblMask = m;
    tblWe   = 1'b1;
    @(negedge clk);
    tblWe   = 1'b0;
  endtask

  task automatic pulseReq(input logic [NUM_VEC-1:0] bits);
    srcReq = srcReq | bits;
    @(negedge clk);
    srcReq = srcReq & ~bits;
  endtask

  task automatic testReset();
    // R1
    check(outValid === 1'b0, "R1", $sformatf("outValid in reset actual %b expected 0", outValid));
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", $sformatf("outValid after reset actual %b expected 0", outValid));
  endtask

  task automatic testLegacyLevel();
    legacyPin = 2'd2;
    srcReq[3] = 1'b1;
    expectDesc(2'd1, 32'h0, 32'h0, 2'd2, 0, "R2");
    srcReq[5] = 1'b1;
    expectNone(6, "R3");
    srcReq[3] = 1'b0;
    expectNone(6, "R3");
    srcReq[5] = 1'b0;
    expectDesc(2'd2, 32'h0, 32'h0, 2'd2, 0, "R3");
    legacyPin = 2'd1;
    srcReq[0] = 1'b1;
    expectDesc(2'd1, 32'h0, 32'h0, 2'd1, 2, "R2");
    srcReq[0] = 1'b0;
    expectDesc(2'd2, 32'h0, 32'h0, 2'd1, 0, "R3");
  endtask

  task automatic testModeSwitch();
    legacyPin = 2'd3;
    srcReq[1] = 1'b1;
    expectDesc(2'd1, 32'h0, 32'h0, 2'd3, 0, "R2");
    pulseReq(8'b0000_0100);
    msiEn = 1'b1;
    expectDesc(2'd2, 32'h0, 32'h0, 2'd3, 0, "R4");
    // R10: edge of vector 2 seen in legacy mode is not served
    expectNone(8, "R10");
    srcReq[1] = 1'b0;
    expectNone(4, "R4");
  endtask

  task automatic testSingleAddr();
    msiAddr    = 32'hFEE0_1000;
    msiData    = 32'h0000_4A40;
    msiVecLog2 = 3'd3;
    pulseReq(8'b0100_0000);
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4A46, 2'd0, 0, "R5");
    msiVecLog2 = 3'd2;
    pulseReq(8'b0100_0000);
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4A42, 2'd0, 0, "R5");
    msiVecLog2 = 3'd7;
    msiData    = 32'h0000_4AFF;
    pulseReq(8'b0000_1000);
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4AE3, 2'd0, 0, "R5");
    msiVecLog2 = 3'd3;
    msiData    = 32'h0000_4A40;
  endtask

  task automatic testPriority();
    pulseReq(8'b1010_0100);
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4A42, 2'd0, 3, "R8");
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4A45, 2'd0, 0, "R8");
    expectDesc(2'd0, 32'hFEE0_1000, 32'h0000_4A47, 2'd0, 0, "R8");
    expectNone(5, "R8");
  endtask

  task automatic testTable();
    writeEntry(4, 32'hFEE0_2000, 32'h0000_0055, 1'b0);
    writeEntry(3, 32'hFEE0_3000, 32'h0000_0033, 1'b1);
    tableEn = 1'b1;
    pulseReq(8'b0001_0000);
    expectDesc(2'd0, 32'hFEE0_2000, 32'h0000_0055, 2'd0, 0, "R6");
    pulseReq(8'b0000_1000);
    expectNone(10, "R7");
    writeEntry(3, 32'hFEE0_3000, 32'h0000_0033, 1'b0);
    expectDesc(2'd0, 32'hFEE0_3000, 32'h0000_0033, 2'd0, 0, "R7");
    // R4: a level held high in table mode yields no assert message
    srcReq[6] = 1'b1;
    writeEntry(6, 32'hFEE0_6000, 32'h0000_0066, 1'b0);
    expectDesc(2'd0, 32'hFEE0_6000, 32'h0000_0066, 2'd0, 0, "R4");
    srcReq[6] = 1'b0;
    expectNone(5, "R4");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    testLegacyLevel();
    testModeSwitch();
    testSingleAddr();
    testPriority();
    testTable();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule